// File: doc/BRIEF.md
# Card Initialization State Tracker

This block runs on the host side and keeps a copy of the state of a removable memory card while the card powers up and is identified. The host command engine reports each command it sends as a one-cycle command event with an opcode and a small argument. Later it reports the card's answer as a one-cycle response event, which carries an accepted flag and a timeout flag. From these events the tracker moves through the states powered-off, idle, ready, identifying, standby and transfer. It also reports the data bus width the card is using and a sticky error flag.

The bus width is 1 bit after every initialization. It changes only when a width change is accepted while the card is in the transfer state. Removing the card, or sending the go-to-idle command, returns the tracker to a known starting point. All outputs are registered and change on the clock edge that samples the event.

Top module: `card_init_tracker`

## Requirements
- R1: After reset, card_state is 0 (powered-off), bus_width is 0 (1-bit), err_flag is 0 and xfer_ready is 0.
- R2: In state 0, the only event that changes anything is a go-to-idle command (cmd_op 0). Every other opcode and every response leaves all outputs unchanged.
- R3: A go-to-idle command with the card present moves card_state to 1 (idle) from any state on the next clock edge. It also clears err_flag and sets bus_width to 0.
- R4: A voltage check (cmd_op 1) issued in state 1 and then accepted moves the state to 2 (ready). If it is rejected, err_flag is set and the state stays 1.
- R5: An identification request (cmd_op 2) accepted in state 2 moves the state to 3 (identifying). An address assignment (cmd_op 3) accepted in state 3 moves the state to 4 (standby).
- R6: A select (cmd_op 4) accepted in state 4 moves the state to 5 (transfer). xfer_ready is 1 exactly when card_state is 5.
- R7: bus_width is 0 in every state other than 5. In state 5, a set-width command (cmd_op 5) that is then accepted loads cmd_arg into bus_width (0 = 1-bit, 1 = 4-bit, 2 = 8-bit when WIDE_OK is 1). An argument of 3, or of 2 when WIDE_OK is 0, is ignored.
- R8: When card_present is low, card_state goes to 0 on the next edge, with bus_width 0 and err_flag 0. It stays there until a go-to-idle command arrives.
- R9: A response with rsp_timeout set to a pending command sets err_flag and leaves card_state and bus_width unchanged. rsp_timeout wins over rsp_ok.
- R10: An opcode that is not legal in the current state (opcodes 6 and 7 are never legal) creates no pending command. A response that arrives with nothing pending changes nothing.
- R11: card_state uses the encoding 0 powered-off, 1 idle, 2 ready, 3 identifying, 4 standby, 5 transfer. Values 6 and 7 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_present | input | 1 | High while a card sits in the slot |
| cmd_valid | input | 1 | One-cycle strobe: a command was sent |
| cmd_op | input | 3 | Command opcode (0 go-idle, 1 voltage check, 2 id request, 3 address, 4 select, 5 set width) |
| cmd_arg | input | 2 | Width code for set-width |
| rsp_valid | input | 1 | One-cycle strobe: the answer to the last command arrived |
| rsp_ok | input | 1 | The card accepted the command |
| rsp_timeout | input | 1 | No answer came in time |
| card_state | output | 3 | Tracked card state |
| bus_width | output | 2 | Data bus width code |
| xfer_ready | output | 1 | Card is selected and can transfer data |
| err_flag | output | 1 | Sticky error (voltage rejected or timeout) |

## Verification
The hardest cases to reach from the ports are the illegal command and state pairings deep in the sequence. An example is an address assignment sent while the card is in standby: to reach it, the card must first be walked through every earlier gate with accepted responses. The bench drives each of states 1 to 4 this way, one fresh walk per test. In each state it tries every opcode with an accepting response and compares the result with the single-step rule: the opcode that equals the state number advances the state, and every other opcode leaves it alone. The timeout and width cases are reached with the same walk, which stops in the identifying or the transfer state.

// File: rtl/card_trk_pkg.sv
// Package: shared encodings for the card initialization tracker.
// Assumes: the state values are fixed by the outside interface (R11).
package card_trk_pkg;
    localparam int ST_W  = 3;
    localparam int OP_W  = 3;
    localparam int BW_W  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_READY = 3'd2,
        ST_IDENT = 3'd3,
        ST_STBY  = 3'd4,
        ST_XFER  = 3'd5
    } card_st_e;

    localparam logic [OP_W-1:0] OP_GO_IDLE = 3'd0;
    localparam logic [OP_W-1:0] OP_VOLT    = 3'd1;
    localparam logic [OP_W-1:0] OP_ID_REQ  = 3'd2;
    localparam logic [OP_W-1:0] OP_ADDR    = 3'd3;
    localparam logic [OP_W-1:0] OP_SELECT  = 3'd4;
    localparam logic [OP_W-1:0] OP_SET_BW  = 3'd5;

    localparam logic [BW_W-1:0] BW_1BIT = 2'd0;
    localparam logic [BW_W-1:0] BW_4BIT = 2'd1;
    localparam logic [BW_W-1:0] BW_8BIT = 2'd2;
endpackage

// File: rtl/card_trk_pending.sv
// Module: holds the command that is waiting for its response.
// Assumes: one command in flight at a time. A command is latched only when
// it is legal in the current state; go-idle and card removal drop it.
module card_trk_pending
    import card_trk_pkg::*;
#(
    parameter bit WIDE_OK = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            card_present,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [BW_W-1:0] cmd_arg,
    input  logic            rsp_valid,
    input  card_st_e        state,
    output logic            pend_vld,
    output logic [OP_W-1:0] pend_op,
    output logic [BW_W-1:0] pend_arg
);
    logic arg_legal;
    logic op_legal;

    // Width argument check; the 8-bit code is a build-time option.
    generate
        if (WIDE_OK) begin : g_wide
            assign arg_legal = (cmd_arg == BW_1BIT) || (cmd_arg == BW_4BIT) ||
                               (cmd_arg == BW_8BIT);
        end else begin : g_narrow
            assign arg_legal = (cmd_arg == BW_1BIT) || (cmd_arg == BW_4BIT);
        end
    endgenerate

    // Decide whether the opcode expects an answer in this state.
    always_comb begin
        case (state)
            ST_IDLE:  op_legal = (cmd_op == OP_VOLT);
            ST_READY: op_legal = (cmd_op == OP_ID_REQ);
            ST_IDENT: op_legal = (cmd_op == OP_ADDR);
            ST_STBY:  op_legal = (cmd_op == OP_SELECT);
            ST_XFER:  op_legal = (cmd_op == OP_SET_BW) && arg_legal;
            default:  op_legal = 1'b0;
        endcase
    end

    // Latch a legal command, retire it on its response.
    always_ff @(posedge clk) begin
        if (!rst_n || !card_present) begin
            pend_vld <= 1'b0;
            pend_op  <= OP_GO_IDLE;
            pend_arg <= BW_1BIT;
        end else if (cmd_valid && cmd_op == OP_GO_IDLE) begin
            pend_vld <= 1'b0;
        end else if (cmd_valid && op_legal) begin
            pend_vld <= 1'b1;
            pend_op  <= cmd_op;
            pend_arg <= cmd_arg;
        end else if (rsp_valid) begin
            pend_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/card_trk_fsm.sv
// Module: card state sequencer and sticky error flag.
// Assumes: responses are only meaningful while a command is pending; a
// timeout beats an accept; only a rejected voltage check counts as error
// among the rejections.
module card_trk_fsm
    import card_trk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            card_present,
    input  logic            go_idle,
    input  logic            rsp_valid,
    input  logic            rsp_ok,
    input  logic            rsp_timeout,
    input  logic            pend_vld,
    input  logic [OP_W-1:0] pend_op,
    output card_st_e        state,
    output logic            err
);
    card_st_e adv_state;
    logic     rsp_live;

    assign rsp_live = rsp_valid && pend_vld;

    // Target state for an accepted response to the pending opcode.
    always_comb begin
        adv_state = state;
        case (pend_op)
            OP_VOLT:   adv_state = ST_READY;
            OP_ID_REQ: adv_state = ST_IDENT;
            OP_ADDR:   adv_state = ST_STBY;
            OP_SELECT: adv_state = ST_XFER;
            default:   adv_state = state;
        endcase
    end

    // State register with removal, go-idle and response handling.
    always_ff @(posedge clk) begin
        if (!rst_n || !card_present) begin
            state <= ST_OFF;
            err   <= 1'b0;
        end else if (go_idle) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else if (rsp_live) begin
            if (rsp_timeout) begin
                err <= 1'b1;
            end else if (rsp_ok) begin
                state <= adv_state;
            end else if (pend_op == OP_VOLT) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/card_trk_width.sv
// Module: data bus width register.
// Assumes: a width change is only pending in the transfer state; every
// restart of initialization returns to 1-bit.
module card_trk_width
    import card_trk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            card_present,
    input  logic            go_idle,
    input  logic            rsp_valid,
    input  logic            rsp_ok,
    input  logic            rsp_timeout,
    input  logic            pend_vld,
    input  logic [OP_W-1:0] pend_op,
    input  logic [BW_W-1:0] pend_arg,
    output logic [BW_W-1:0] width
);
    // Load the confirmed width, fall back to 1-bit on any restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !card_present || go_idle) begin
            width <= BW_1BIT;
        end else if (rsp_valid && pend_vld && rsp_ok && !rsp_timeout &&
                     pend_op == OP_SET_BW) begin
            width <= pend_arg;
        end
    end
endmodule

// File: rtl/card_init_tracker.sv
// Module: top of the host-side card initialization tracker.
// Assumes: cmd_valid and rsp_valid are one-cycle strobes from the command
// engine, and a response refers to the latest command.
module card_init_tracker
    import card_trk_pkg::*;
#(
    parameter bit WIDE_OK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       card_present,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [1:0] cmd_arg,
    input  logic       rsp_valid,
    input  logic       rsp_ok,
    input  logic       rsp_timeout,
    output logic [2:0] card_state,
    output logic [1:0] bus_width,
    output logic       xfer_ready,
    output logic       err_flag
);
    card_st_e        st;
    logic            pend_vld;
    logic [OP_W-1:0] pend_op;
    logic [BW_W-1:0] pend_arg;
    logic            go_idle;

    assign go_idle = cmd_valid && (cmd_op == OP_GO_IDLE);

    card_trk_pending #(.WIDE_OK(WIDE_OK)) u_pend (
        .clk(clk), .rst_n(rst_n), .card_present(card_present),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .state(st),
        .pend_vld(pend_vld), .pend_op(pend_op), .pend_arg(pend_arg)
    );

    card_trk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .card_present(card_present),
        .go_idle(go_idle), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_timeout(rsp_timeout), .pend_vld(pend_vld), .pend_op(pend_op),
        .state(st), .err(err_flag)
    );

    card_trk_width u_bw (
        .clk(clk), .rst_n(rst_n), .card_present(card_present),
        .go_idle(go_idle), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_timeout(rsp_timeout), .pend_vld(pend_vld), .pend_op(pend_op),
        .pend_arg(pend_arg), .width(bus_width)
    );

    assign card_state = st;
    assign xfer_ready = (st == ST_XFER);
endmodule

// File: rtl/card_init_tracker_chk.sv
// Checker: temporal properties of the tracker ports, bound to the top.
module card_init_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       card_present,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       rsp_valid,
    input logic       rsp_timeout,
    input logic [2:0] card_state,
    input logic [1:0] bus_width,
    input logic       xfer_ready,
    input logic       err_flag
);
    // Removal forces powered-off with a clean width and error.
    assert_removal_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !card_present |=> card_state == 3'd0 && bus_width == 2'd0 && !err_flag);

    // Go-idle with the card present lands in idle at 1-bit, error cleared.
    assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_present && cmd_valid && cmd_op == 3'd0
        |=> card_state == 3'd1 && bus_width == 2'd0 && !err_flag);

    // Outside transfer the width stays at 1-bit.
    assert_width_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        card_state != 3'd5 |-> bus_width == 2'd0);

    // A timeout never moves the state; it sets the error if it was live.
    assert_timeout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        card_present && rsp_valid && rsp_timeout && !cmd_valid
        |=> card_state == $past(card_state));

    // Ready is only entered from idle.
    assert_ready_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        card_state == 3'd2 && $past(card_state) != 3'd2 |-> $past(card_state) == 3'd1);

    // Transfer is only entered from standby.
    assert_xfer_from_stby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_ready) |-> $past(card_state) == 3'd4);

    // Powered-off is left only through idle.
    assert_off_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(card_state) == 3'd0 && card_state != 3'd0 |-> card_state == 3'd1);

    // Only the six encodings ever appear.
    assert_legal_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        card_state <= 3'd5);
endmodule

bind card_init_tracker card_init_tracker_chk u_chk (.*);

// File: tb/card_init_tracker_tb.sv
`timescale 1ns/1ps
module card_init_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_present = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_arg = 2'd0;
    logic       rsp_valid = 1'b0;
    logic       rsp_ok = 1'b0;
    logic       rsp_timeout = 1'b0;
    logic [2:0] card_state;
    logic [1:0] bus_width;
    logic       xfer_ready;
    logic       err_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    card_init_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .card_present(card_present),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_timeout(rsp_timeout),
        .card_state(card_state), .bus_width(bus_width),
        .xfer_ready(xfer_ready), .err_flag(err_flag)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Full snapshot check of all outputs.
    task automatic chk_all(input int st, input int bw, input int er, input string tag);
        chk(card_state, st, {tag, " state"});
        chk(bus_width, bw, {tag, " width"});
        chk(err_flag, er, {tag, " err"});
        chk(xfer_ready, (st == 5) ? 1 : 0, {tag, " ready"});
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [1:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic ok, input logic to);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_ok = ok; rsp_timeout = to;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_ok = 1'b0; rsp_timeout = 1'b0;
    endtask

    // Walk the card from a fresh go-idle up to state s with accepted answers.
    task automatic reach(input int s);
        send_cmd(3'd0, 2'd0);
        for (int k = 1; k < s; k++) begin
            send_cmd(3'(k), 2'd0);
            send_rsp(1'b1, 1'b0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(0, 0, 0, "R1 reset");

        // R2: every non-idle opcode in powered-off, with answers, does nothing.
        for (int op = 1; op < 8; op++) begin
            send_cmd(3'(op), 2'd1);
            send_rsp(1'b1, 1'b0);
            send_rsp(1'b0, 1'b1);
            chk_all(0, 0, 0, "R2 off ignores op");
        end

        // R3: go-idle from powered-off.
        send_cmd(3'd0, 2'd0);
        chk_all(1, 0, 0, "R3 idle from off");

        // R4: rejected voltage check sets error, state stays idle.
        send_cmd(3'd1, 2'd0);
        send_rsp(1'b0, 1'b0);
        chk_all(1, 0, 1, "R4 voltage reject");
        send_cmd(3'd0, 2'd0);
        chk_all(1, 0, 0, "R3 go-idle clears error");

        // R4/R5/R6/R10/R11: sweep each mid state against every opcode.
        for (int s = 1; s <= 4; s++) begin
            for (int op = 1; op < 8; op++) begin
                reach(s);
                send_cmd(3'(op), 2'd1);
                send_rsp(1'b1, 1'b0);
                chk_all((op == s) ? s + 1 : s, 0, 0, "R5 R10 sweep step");
                send_rsp(1'b1, 1'b0);
                chk_all((op == s) ? s + 1 : s, 0, 0, "R10 stray response");
            end
        end

        // R6/R7: width changes in transfer.
        reach(5);
        chk_all(5, 0, 0, "R6 transfer");
        send_cmd(3'd5, 2'd1);
        chk(bus_width, 0, "R7 width before answer");
        send_rsp(1'b1, 1'b0);
        chk_all(5, 1, 0, "R7 4-bit");
        send_cmd(3'd5, 2'd2);
        send_rsp(1'b1, 1'b0);
        chk_all(5, 2, 0, "R7 8-bit");
        send_cmd(3'd5, 2'd3);
        send_rsp(1'b1, 1'b0);
        chk_all(5, 2, 0, "R7 code 3 ignored");
        send_cmd(3'd5, 2'd0);
        send_rsp(1'b0, 1'b0);
        chk_all(5, 2, 0, "R7 rejected keeps width");
        send_cmd(3'd5, 2'd0);
        send_rsp(1'b1, 1'b1);
        chk_all(5, 2, 1, "R9 timeout in transfer");
        send_cmd(3'd0, 2'd0);
        chk_all(1, 0, 0, "R3 idle from transfer");

        // R9: timeout during identification.
        reach(3);
        send_cmd(3'd3, 2'd0);
        send_rsp(1'b1, 1'b1);
        chk_all(3, 0, 1, "R9 timeout in ident");

        // R8: removal from transfer, then reinsertion stays off.
        reach(5);
        send_cmd(3'd5, 2'd1);
        send_rsp(1'b1, 1'b0);
        chk_all(5, 1, 0, "R8 pre-removal");
        @(negedge clk);
        card_present = 1'b0;
        @(negedge clk);
        chk_all(0, 0, 0, "R8 removal");
        card_present = 1'b1;
        repeat (3) @(negedge clk);
        send_rsp(1'b1, 1'b0);
        chk_all(0, 0, 0, "R8 stays off after insert");
        send_cmd(3'd0, 2'd0);
        chk_all(1, 0, 0, "R8 R3 restart");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule